// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

A purely combinational address mapper that sits between an instruction decoder and a banked data memory. It receives a 7-bit operand offset from the instruction, two bank-select bits, an indirect high-select bit and an 8-bit pointer value. From these it builds a 9-bit physical data-memory address. The address is made of a 2-bit bank and a 7-bit offset. Each bank holds 128 locations. Special-function registers occupy the low offsets of each bank, and general-purpose storage lies above them.

Operand offset 00h is not a storage location. It is the indirect-access alias. When the operand names 00h, the pointer supplies the low eight address bits and the indirect high-select bit supplies the top bit. Several folding rules then apply, in this order:
- A bank index beyond the configured bank count wraps.
- A chosen set of special-register offsets is shared by every bank.
- A common upper region of every bank lands on bank 0.
- An optional hole range in bank 1 folds onto bank 0.

Locations that are unimplemented are flagged so that reads return zero and writes are dropped. An indirect access whose pointer names the alias itself is treated the same way.

Top module: `dm_addr_mapper`

## Requirements
- R1: With a non-zero operand offset and no folding rule matching, the physical address equals {bank_sel, op_addr}.
- R2: With operand offset 00h, the raw address is {ind_hi, ptr}: bit 8 comes from ind_hi, bits 7..0 from ptr. The folding rules then apply to it as for a direct access, so the physical offset always equals ptr[6:0].
- R3: An indirect access whose pointer offset ptr[6:0] is 00h drives impl_o=0 and rd_zero_o=1.
- R4: When the common region is enabled and there is more than one bank, offsets COMMON_LO (default 70h) through 7Fh map to bank 0 from every bank. Offset 6Fh keeps its bank.
- R5: Offsets set in SHARED_MASK map to bank 0 from every bank. The default mask covers 00h, 02h, 03h, 04h, 0Ah and 0Bh.
- R6: Offsets set in UNIMP_MASK drive impl_o=0 and rd_zero_o=1 in every bank. The default mask covers 07h, 08h and 09h.
- R7: sfr_o is 1 exactly when the physical offset is below SFR_LIMIT (default 20h). So 1Fh gives 1 and 20h gives 0.
- R8: wr_en_o equals wr_req_i AND impl_o, so a write to an unimplemented location is dropped.
- R9: When HOLE_EN is set, bank 1 offsets HOLE_LO through HOLE_HI (default 0Ch to 2Fh) map to the same offsets in bank 0. Offset 30h of bank 1 stays in bank 1.
- R10: The bank index is masked to NUM_BANKS-1. With NUM_BANKS=2, bank 3 acts as bank 1 and bank 2 acts as bank 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_addr_i | input | 7 | Operand offset from the instruction; 00h selects indirect access |
| bank_sel_i | input | 2 | Bank-select status bits used for direct access |
| ind_hi_i | input | 1 | High-order address bit used for indirect access |
| ptr_i | input | 8 | Pointer register value used for indirect access |
| wr_req_i | input | 1 | Write request for this access |
| phys_addr_o | output | 9 | Physical data-memory address {bank, offset} |
| impl_o | output | 1 | Location is implemented |
| sfr_o | output | 1 | Location is in the special-function range |
| rd_zero_o | output | 1 | Read data must be forced to zero |
| wr_en_o | output | 1 | Write enable passed to storage |

## Verification
The interesting overlap is an indirect access whose pointer lands on a folded location. In that case the indirect source selection and a bank-folding rule act on the same access. An example is pointer 83h with ind_hi clear: the access names a shared register from bank 1 and must resolve to 003h. Another is pointer F2h, which names the common region and must resolve to 072h. The pointer-names-alias case (pointer 80h with ind_hi set) also combines two rules: the shared-offset fold and the read-zero flag. It is judged on both the address (000h) and the flags. A second instance, with two banks and the hole rule enabled, provokes bank wrap and hole folding on the same access (bank 3, offset 0Ch resolves to 00Ch).

// File: rtl/dm_map_pkg.sv
package dm_map_pkg;

    localparam int OFS_W  = 7;
    localparam int BANK_W = 2;
    localparam int PHYS_W = OFS_W + BANK_W;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        bank_t bank;
        ofs_t  ofs;
    } dm_addr_t;

    // Test a 32-entry per-offset mask; offsets at or above 20h never match.
    function automatic logic mask_hit(input logic [31:0] mask, input ofs_t ofs);
        return (ofs[OFS_W-1:5] == '0) && mask[ofs[4:0]];
    endfunction

endpackage

// File: rtl/dm_src_select.sv
module dm_src_select
    import dm_map_pkg::*;
(
    input  ofs_t     op_addr_i,
    input  bank_t    bank_sel_i,
    input  logic     ind_hi_i,
    input  logic [7:0] ptr_i,
    output dm_addr_t raw_o,
    output logic     indirect_o
);

    always_comb begin
        indirect_o = (op_addr_i == '0);
        if (indirect_o) begin
            raw_o.bank = {ind_hi_i, ptr_i[7]};
            raw_o.ofs  = ptr_i[6:0];
        end else begin
            raw_o.bank = bank_sel_i;
            raw_o.ofs  = op_addr_i;
        end
    end

endmodule

// File: rtl/dm_bank_fold.sv
module dm_bank_fold
    import dm_map_pkg::*;
#(
    parameter int          NUM_BANKS   = 4,
    parameter bit          COMMON_EN   = 1'b1,
    parameter logic [6:0]  COMMON_LO   = 7'h70,
    parameter logic [31:0] SHARED_MASK = 32'h0000_0C1D,
    parameter bit          HOLE_EN     = 1'b0,
    parameter logic [6:0]  HOLE_LO     = 7'h0C,
    parameter logic [6:0]  HOLE_HI     = 7'h2F
) (
    input  dm_addr_t raw_i,
    output dm_addr_t phys_o
);

    localparam bank_t BANK_MASK  = bank_t'(NUM_BANKS - 1);
    localparam bit    COMMON_ACT = COMMON_EN && (NUM_BANKS > 1);

    bank_t wrapped;
    logic  hit_shared;
    logic  hit_common;
    logic  hit_hole;

    always_comb begin
        wrapped    = raw_i.bank & BANK_MASK;
        hit_shared = mask_hit(SHARED_MASK, raw_i.ofs);
        hit_common = COMMON_ACT && (raw_i.ofs >= COMMON_LO);
        hit_hole   = HOLE_EN && (wrapped == bank_t'(1)) &&
                     (raw_i.ofs >= HOLE_LO) && (raw_i.ofs <= HOLE_HI);
        phys_o.ofs  = raw_i.ofs;
        phys_o.bank = (hit_shared || hit_common || hit_hole) ? '0 : wrapped;
    end

endmodule

// File: rtl/dm_attr_decode.sv
module dm_attr_decode
    import dm_map_pkg::*;
#(
    parameter logic [31:0] UNIMP_MASK = 32'h0000_0380,
    parameter logic [6:0]  SFR_LIMIT  = 7'h20
) (
    input  ofs_t  ofs_i,
    input  logic  indirect_i,
    input  logic  wr_req_i,
    output logic  impl_o,
    output logic  sfr_o,
    output logic  rd_zero_o,
    output logic  wr_en_o
);

    logic self_ref;
    logic hole;

    always_comb begin
        self_ref  = indirect_i && (ofs_i == '0);
        hole      = mask_hit(UNIMP_MASK, ofs_i);
        impl_o    = !(self_ref || hole);
        sfr_o     = (ofs_i < SFR_LIMIT);
        rd_zero_o = !impl_o;
        wr_en_o   = wr_req_i && impl_o;
    end

endmodule

// File: rtl/dm_addr_mapper.sv
module dm_addr_mapper
    import dm_map_pkg::*;
#(
    parameter int          NUM_BANKS   = 4,
    parameter bit          COMMON_EN   = 1'b1,
    parameter logic [6:0]  COMMON_LO   = 7'h70,
    parameter logic [31:0] SHARED_MASK = 32'h0000_0C1D,
    parameter logic [31:0] UNIMP_MASK  = 32'h0000_0380,
    parameter logic [6:0]  SFR_LIMIT   = 7'h20,
    parameter bit          HOLE_EN     = 1'b0,
    parameter logic [6:0]  HOLE_LO     = 7'h0C,
    parameter logic [6:0]  HOLE_HI     = 7'h2F
) (
    input  logic [6:0] op_addr_i,
    input  logic [1:0] bank_sel_i,
    input  logic       ind_hi_i,
    input  logic [7:0] ptr_i,
    input  logic       wr_req_i,
    output logic [8:0] phys_addr_o,
    output logic       impl_o,
    output logic       sfr_o,
    output logic       rd_zero_o,
    output logic       wr_en_o
);

    dm_addr_t raw;
    dm_addr_t phys;
    logic     indirect;

    dm_src_select src_i (
        .op_addr_i  (op_addr_i),
        .bank_sel_i (bank_sel_i),
        .ind_hi_i   (ind_hi_i),
        .ptr_i      (ptr_i),
        .raw_o      (raw),
        .indirect_o (indirect)
    );

    dm_bank_fold #(
        .NUM_BANKS   (NUM_BANKS),
        .COMMON_EN   (COMMON_EN),
        .COMMON_LO   (COMMON_LO),
        .SHARED_MASK (SHARED_MASK),
        .HOLE_EN     (HOLE_EN),
        .HOLE_LO     (HOLE_LO),
        .HOLE_HI     (HOLE_HI)
    ) fold_i (
        .raw_i  (raw),
        .phys_o (phys)
    );

    dm_attr_decode #(
        .UNIMP_MASK (UNIMP_MASK),
        .SFR_LIMIT  (SFR_LIMIT)
    ) attr_i (
        .ofs_i      (phys.ofs),
        .indirect_i (indirect),
        .wr_req_i   (wr_req_i),
        .impl_o     (impl_o),
        .sfr_o      (sfr_o),
        .rd_zero_o  (rd_zero_o),
        .wr_en_o    (wr_en_o)
    );

    assign phys_addr_o = phys;

endmodule

// File: rtl/dm_addr_mapper_chk.sv
module dm_addr_mapper_chk #(
    parameter int          NUM_BANKS   = 4,
    parameter bit          COMMON_EN   = 1'b1,
    parameter logic [6:0]  COMMON_LO   = 7'h70,
    parameter logic [31:0] SHARED_MASK = 32'h0000_0C1D
) (
    input logic [6:0] op_addr_i,
    input logic       ind_hi_i,
    input logic [7:0] ptr_i,
    input logic       wr_req_i,
    input logic [8:0] phys_addr_o,
    input logic       impl_o,
    input logic       rd_zero_o,
    input logic       wr_en_o
);

    logic known;
    logic [6:0] exp_ofs;

    always_comb begin
        known   = !$isunknown({op_addr_i, ind_hi_i, ptr_i, wr_req_i,
                               phys_addr_o, impl_o, rd_zero_o, wr_en_o});
        exp_ofs = (op_addr_i == 7'h00) ? ptr_i[6:0] : op_addr_i;
        if (known) begin
            // R2: the offset source follows the alias selection
            a_r2_offset_src: assert (phys_addr_o[6:0] == exp_ofs);
            // R8: no write reaches an unimplemented location
            a_r8_wr_gated: assert (!wr_en_o || (impl_o && wr_req_i));
            // R3 and R6: anything not implemented reads as zero
            a_r6_unimpl_reads_zero: assert (impl_o || rd_zero_o);
            // R3: an indirect access that names the alias is not implemented
            a_r3_self_ref: assert (!(op_addr_i == 7'h00 && ptr_i[6:0] == 7'h00) || !impl_o);
            // R4: the common region lives only in bank 0
            a_r4_common_bank0: assert (!(COMMON_EN && NUM_BANKS > 1 &&
                                        phys_addr_o[6:0] >= COMMON_LO) ||
                                      phys_addr_o[8:7] == 2'b00);
            // R5: shared offsets live only in bank 0
            a_r5_shared_bank0: assert (!(phys_addr_o[6:5] == 2'b00 &&
                                        SHARED_MASK[phys_addr_o[4:0]]) ||
                                      phys_addr_o[8:7] == 2'b00);
            // R10: never a bank beyond the configured count
            a_r10_bank_range: assert (int'(phys_addr_o[8:7]) < NUM_BANKS);
        end
    end

endmodule

bind dm_addr_mapper dm_addr_mapper_chk #(
    .NUM_BANKS   (NUM_BANKS),
    .COMMON_EN   (COMMON_EN),
    .COMMON_LO   (COMMON_LO),
    .SHARED_MASK (SHARED_MASK)
) chk_i (
    .op_addr_i   (op_addr_i),
    .ind_hi_i    (ind_hi_i),
    .ptr_i       (ptr_i),
    .wr_req_i    (wr_req_i),
    .phys_addr_o (phys_addr_o),
    .impl_o      (impl_o),
    .rd_zero_o   (rd_zero_o),
    .wr_en_o     (wr_en_o)
);

// File: tb/dm_addr_mapper_tb_top.sv
module dm_addr_mapper_tb_top;

    typedef struct packed {
        logic [6:0] op;
        logic [1:0] bk;
        logic       ih;
        logic [7:0] ptr;
        logic       wr;
        logic [8:0] phys;
        logic       impl;
        logic       sfr;
        logic       rz;
        logic       wre;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{7'h25, 2'd1, 1'b0, 8'h00, 1'b1, 9'h0A5, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1},
        '{7'h45, 2'd3, 1'b0, 8'h00, 1'b0, 9'h1C5, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1},
        '{7'h01, 2'd2, 1'b0, 8'h00, 1'b0, 9'h101, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1},
        '{7'h03, 2'd3, 1'b0, 8'h00, 1'b0, 9'h003, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5},
        '{7'h0B, 2'd2, 1'b0, 8'h00, 1'b1, 9'h00B, 1'b1, 1'b1, 1'b0, 1'b1, 4'd5},
        '{7'h75, 2'd2, 1'b0, 8'h00, 1'b0, 9'h075, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
        '{7'h7F, 2'd1, 1'b0, 8'h00, 1'b0, 9'h07F, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
        '{7'h6F, 2'd3, 1'b0, 8'h00, 1'b0, 9'h1EF, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
        '{7'h08, 2'd1, 1'b0, 8'h00, 1'b1, 9'h088, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6},
        '{7'h00, 2'd0, 1'b1, 8'h30, 1'b0, 9'h130, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
        '{7'h00, 2'd2, 1'b0, 8'h83, 1'b0, 9'h003, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2},
        '{7'h00, 2'd1, 1'b1, 8'h80, 1'b1, 9'h000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3},
        '{7'h00, 2'd3, 1'b0, 8'hF2, 1'b0, 9'h072, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
        '{7'h1F, 2'd1, 1'b0, 8'h00, 1'b0, 9'h09F, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},
        '{7'h20, 2'd1, 1'b0, 8'h00, 1'b1, 9'h0A0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7},
        '{7'h09, 2'd0, 1'b0, 8'h00, 1'b1, 9'h009, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [6:0] op;
    logic [1:0] bk;
    logic       ih;
    logic [7:0] ptr;
    logic       wr;
    logic [8:0] pa_a, pa_b;
    logic       im_a, sf_a, rz_a, we_a;
    logic       im_b, sf_b, rz_b, we_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    dm_addr_mapper dut_i (
        .op_addr_i(op), .bank_sel_i(bk), .ind_hi_i(ih), .ptr_i(ptr), .wr_req_i(wr),
        .phys_addr_o(pa_a), .impl_o(im_a), .sfr_o(sf_a), .rd_zero_o(rz_a), .wr_en_o(we_a)
    );

    dm_addr_mapper #(
        .NUM_BANKS(2), .COMMON_EN(1'b0), .UNIMP_MASK(32'h0), .HOLE_EN(1'b1)
    ) dut2_i (
        .op_addr_i(op), .bank_sel_i(bk), .ind_hi_i(ih), .ptr_i(ptr), .wr_req_i(wr),
        .phys_addr_o(pa_b), .impl_o(im_b), .sfr_o(sf_b), .rd_zero_o(rz_b), .wr_en_o(we_b)
    );

    function automatic string tag_name(input logic [3:0] n);
        case (n)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got phys=%h impl/sfr/rz/we=%b expected phys=%h impl/sfr/rz/we=%b",
                     tag, act[12:4], act[3:0], exp[12:4], exp[3:0]);
        end
    endtask

    task automatic apply(input logic [6:0] o, input logic [1:0] b, input logic h,
                         input logic [7:0] p, input logic w);
        @(posedge clk);
        op = o; bk = b; ih = h; ptr = p; wr = w;
        @(negedge clk);
    endtask

    initial begin
        op = '0; bk = '0; ih = 1'b0; ptr = '0; wr = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state: all-zero inputs alias through a zero pointer, R3
        check("R3", {pa_a, im_a, sf_a, rz_a, we_a}, {9'h000, 4'b0110});

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].op, TBL[i].bk, TBL[i].ih, TBL[i].ptr, TBL[i].wr);
            check(tag_name(TBL[i].req), {pa_a, im_a, sf_a, rz_a, we_a},
                  {TBL[i].phys, TBL[i].impl, TBL[i].sfr, TBL[i].rz, TBL[i].wre});
        end

        // R9: hole folding in the two-bank instance, both boundaries and just beyond
        apply(7'h0C, 2'd1, 1'b0, 8'h00, 1'b1);
        check("R9", {pa_b, im_b, sf_b, rz_b, we_b}, {9'h00C, 4'b1101});
        apply(7'h2F, 2'd1, 1'b0, 8'h00, 1'b0);
        check("R9", {pa_b, im_b, sf_b, rz_b, we_b}, {9'h02F, 4'b1000});
        apply(7'h30, 2'd1, 1'b0, 8'h00, 1'b0);
        check("R9", {pa_b, im_b, sf_b, rz_b, we_b}, {9'h0B0, 4'b1000});
        // R10: bank wrap, combined with the hole fold
        apply(7'h0C, 2'd3, 1'b0, 8'h00, 1'b0);
        check("R10", {pa_b, im_b, sf_b, rz_b, we_b}, {9'h00C, 4'b1100});
        apply(7'h40, 2'd2, 1'b0, 8'h00, 1'b0);
        check("R10", {pa_b, im_b, sf_b, rz_b, we_b}, {9'h040, 4'b1000});
        apply(7'h50, 2'd3, 1'b0, 8'h00, 1'b0);
        check("R10", {pa_b, im_b, sf_b, rz_b, we_b}, {9'h0D0, 4'b1000});
        // R4: common region disabled keeps bank 1
        apply(7'h75, 2'd1, 1'b0, 8'h00, 1'b0);
        check("R4", {pa_b, im_b, sf_b, rz_b, we_b}, {9'h0F5, 4'b1000});
        // R6: the same offset is implemented when the mask is empty, and writes pass (R8)
        apply(7'h08, 2'd0, 1'b0, 8'h00, 1'b1);
        check("R8", {pa_b, im_b, sf_b, rz_b, we_b}, {9'h008, 4'b1101});
        check("R6", {pa_a, im_a, sf_a, rz_a, we_a}, {9'h008, 4'b0110});

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule